// File: doc/BRIEF.md
# FIFO-Fed Pulse-Width Modulator

This block produces one pulse-width modulated output. The waveform is set through four word-aligned registers on a simple single-cycle bus: control, status, sample and period. Software pushes duty values into a four-entry sample queue. A counter runs at a prescaled rate from one of three clock sources. At a period boundary the counter takes the next duty value from the queue. A repeat setting can make one value last for 2, 4 or 8 periods, and when the queue runs dry the last value stays in force.

One output period lasts the period register value plus two counting steps. The pin can be driven normal, inverted or forced low. A software reset bit in the control word clears the whole block over a few cycles, and it reads back as set until that clearing is done. The status word reports queue occupancy and four sticky event flags that software clears by writing 1.

Top module: `pwm_fifo_gen`

## Requirements
- R1: The registers sit at control 0x00, status 0x04, sample 0x0C and period 0x10. The control fields read back as written: enable bit 0, repeat bits 2:1, prescale bits 15:4, clock source bits 17:16, output mode bits 19:18 and four stored low-power bits 25:22. All other control bits read 0. The period register resets to 0xFFFE.
- R2: One output period is min(period, 0xFFFE) + 2 counting steps, so 0xFFFF acts as 0xFFFE. At the end of a period the counter wraps to 0.
- R3: A counting step takes prescale-field + 1 source ticks, so a field value of 0 counts on every tick.
- R4: Clock source 0 freezes the counter. Source 1 ticks on every clock. Source 2 ticks on the hf_tick input and source 3 on the lf_tick input.
- R5: Output mode 0 drives the waveform as is, mode 1 drives its complement, and modes 2 and 3 hold the pin low.
- R6: In normal mode the output is high while the count is below the active sample. It rises at the wrap to 0 and falls when the count reaches the sample. A sample of 0 keeps the output low, and a sample above the last count keeps it high.
- R7: Repeat code 0, 1, 2 or 3 keeps each sample for 1, 2, 4 or 8 periods.
- R8: The sample queue holds 4 entries, and status bits 2:0 give its occupancy. Enabling loads the head entry. After that, a new entry is taken only at a wrap where the repeat count has expired. With the queue empty, the active sample is held.
- R9: A sample write while the queue is full is dropped and sets status bit 6.
- R10: Status bit 3 is set at reset and whenever a pop empties the queue. Bit 4 is set at every wrap and bit 5 when the count reaches the sample. Writing 1 to any of bits 3 to 6 clears it.
- R11: Writing control bit 3 starts a software reset. While it runs, bit 3 reads 1 and bus writes are ignored. It clears control, status, queue and counter, and restores the period register to 0xFFFE. Then bit 3 reads 0.
- R12: A read of the sample register returns the active sample while the counter runs, and 0 while the block is disabled.
- R13: While the enable bit is 0 the counter stays at 0 and the waveform before the output mode is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hf_tick | input | 1 | Tick enable for clock source 2 |
| lf_tick | input | 1 | Tick enable for clock source 3 |
| bus_addr | input | 5 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 1 | Modulated output |

## Verification
A register write takes effect at the clock edge that samples it, and read data follows the address in the same cycle. The bench therefore drives on the falling edge and reads one falling edge after a write. Enabling loads the head sample one edge after the enable is stored, and the output rises at that edge. Every waveform check measures whole high runs or rise-to-rise spans instead of absolute cycle numbers. The first span is skipped whenever the tick phase makes it partial. A software reset is busy for four cycles after the write edge, and the bench polls the busy bit before moving on.

// File: rtl/pwm_fifo_pkg.sv
package pwm_fifo_pkg;

  localparam int CNT_W  = 16;
  localparam int PRE_W  = 12;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;

  localparam logic [CNT_W-1:0] PR_MAX = 16'hFFFE;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_SAMP = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_PER  = 5'h10;

  localparam int CB_SWR = 3;
  localparam int SB_FE  = 3;
  localparam int SB_ROV = 4;
  localparam int SB_CMP = 5;
  localparam int SB_FWE = 6;

  typedef enum logic [1:0] {SRC_OFF, SRC_BUS, SRC_HF, SRC_LF} clk_src_e;
  typedef enum logic [1:0] {OUT_NORM, OUT_INV, OUT_LOW, OUT_LOW2} out_cfg_e;

  typedef struct packed {
    logic [3:0]       lp;
    out_cfg_e         outcfg;
    clk_src_e         src;
    logic [PRE_W-1:0] presc;
    logic [1:0]       rep;
    logic             en;
  } ctrl_t;

  // last count value of a period: clamp, then one below the length (value + 2)
  function automatic logic [CNT_W-1:0] period_last(input logic [CNT_W-1:0] pr);
    logic [CNT_W-1:0] c;
    c = (pr >= PR_MAX) ? PR_MAX : pr;
    return c + 1'b1;
  endfunction

  // number of extra periods a sample is kept for, per repeat code
  function automatic logic [2:0] rep_last(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd0;
      2'd1:    return 3'd1;
      2'd2:    return 3'd3;
      default: return 3'd7;
    endcase
  endfunction

  function automatic logic shape_out(input logic raw, input out_cfg_e cfg);
    case (cfg)
      OUT_NORM: return raw;
      OUT_INV:  return ~raw;
      default:  return 1'b0;
    endcase
  endfunction

  function automatic ctrl_t ctrl_unpack(input logic [DATA_W-1:0] d);
    ctrl_t c;
    c.en     = d[0];
    c.rep    = d[2:1];
    c.presc  = d[15:4];
    c.src    = clk_src_e'(d[17:16]);
    c.outcfg = out_cfg_e'(d[19:18]);
    c.lp     = d[25:22];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_pack(input ctrl_t c, input logic busy);
    logic [DATA_W-1:0] d;
    d        = '0;
    d[0]     = c.en;
    d[2:1]   = c.rep;
    d[3]     = busy;
    d[15:4]  = c.presc;
    d[17:16] = c.src;
    d[19:18] = c.outcfg;
    d[25:22] = c.lp;
    return d;
  endfunction

endpackage

// File: rtl/pwm_sample_fifo.sv
module pwm_sample_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [OCC_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt_q == OCC_W'(DEPTH));
  assign empty = (cnt_q == '0);
  assign count = cnt_q;
  assign head  = mem[rd_q];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push && !full) wr_q <= ptr_inc(wr_q);
      if (pop && !empty) rd_q <= ptr_inc(rd_q);
      cnt_q <= cnt_q + OCC_W'(push && !full) - OCC_W'(pop && !empty);
    end
  end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_fifo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  clk_src_e         src,
  input  logic             hf_tick,
  input  logic             lf_tick,
  input  logic [PRE_W-1:0] presc,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             adv,
  output logic             roll
);
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic             tick;

  always_comb begin
    case (src)
      SRC_OFF: tick = 1'b0;
      SRC_BUS: tick = 1'b1;
      SRC_HF:  tick = hf_tick;
      default: tick = lf_tick;
    endcase
  end

  assign last = period_last(period);
  assign adv  = run && !clr && tick && (pre_q >= presc);
  assign roll = adv && (cnt_q >= last);
  assign cnt  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (clr || !run) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (tick) begin
      if (pre_q >= presc) begin
        pre_q <= '0;
        cnt_q <= roll ? '0 : cnt_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwm_duty_sel.sv
module pwm_duty_sel
  import pwm_fifo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             roll,
  input  logic [1:0]       rep_code,
  input  logic             fifo_empty,
  input  logic [CNT_W-1:0] fifo_head,
  output logic             pop,
  output logic [CNT_W-1:0] active,
  output logic             loaded,
  output logic [2:0]       rep_cnt
);
  logic [CNT_W-1:0] act_q;
  logic             ld_q;
  logic [2:0]       rep_q;
  logic             rep_done;

  assign rep_done = (rep_q >= rep_last(rep_code));
  assign pop      = en && !clr && !fifo_empty && (!ld_q || (roll && rep_done));
  assign active   = act_q;
  assign loaded   = ld_q;
  assign rep_cnt  = rep_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      ld_q  <= 1'b0;
      rep_q <= '0;
    end else if (clr) begin
      act_q <= '0;
      ld_q  <= 1'b0;
      rep_q <= '0;
    end else if (!en) begin
      ld_q  <= 1'b0;
      rep_q <= '0;
    end else if (!ld_q) begin
      ld_q  <= 1'b1;
      rep_q <= '0;
      if (!fifo_empty) act_q <= fifo_head;
    end else if (roll) begin
      if (rep_done) begin
        rep_q <= '0;
        if (!fifo_empty) act_q <= fifo_head;
      end else begin
        rep_q <= rep_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwm_fifo_gen.sv
module pwm_fifo_gen
  import pwm_fifo_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int SWR_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hf_tick,
  input  logic              lf_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwm_out
);
  localparam int OCC_W = $clog2(FIFO_DEPTH + 1);
  localparam int SWR_W = $clog2(SWR_CYCLES + 1);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] per_q;
  logic [SWR_W-1:0] swr_q;
  logic             swr_busy;
  logic             fe_q, rov_q, cmp_q, fwe_q;

  logic wr_ctrl, wr_stat, wr_samp, wr_per, swr_req;

  logic [OCC_W-1:0] occ;
  logic             fifo_full, fifo_empty, push, pop;
  logic [CNT_W-1:0] fifo_head;

  logic [CNT_W-1:0] tb_cnt, active;
  logic             tb_adv, tb_roll, loaded;
  logic [2:0]       rep_cnt;

  // named events used by the flags and the checker
  logic             cmp_evt, fe_evt, fwe_evt, raw_wave;
  logic             ctrl_en;
  logic [1:0]       ctrl_out;

  assign swr_busy = (swr_q != '0);
  assign wr_ctrl  = bus_wr && !swr_busy && (bus_addr == OFS_CTRL);
  assign wr_stat  = bus_wr && !swr_busy && (bus_addr == OFS_STAT);
  assign wr_samp  = bus_wr && !swr_busy && (bus_addr == OFS_SAMP);
  assign wr_per   = bus_wr && !swr_busy && (bus_addr == OFS_PER);
  assign swr_req  = wr_ctrl && bus_wdata[CB_SWR];
  assign ctrl_en  = ctrl_q.en;
  assign ctrl_out = ctrl_q.outcfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      per_q  <= PR_MAX;
      swr_q  <= '0;
    end else if (swr_req) begin
      ctrl_q <= '0;
      per_q  <= PR_MAX;
      swr_q  <= SWR_W'(SWR_CYCLES);
    end else if (swr_busy) begin
      swr_q  <= swr_q - 1'b1;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_unpack(bus_wdata);
      if (wr_per)  per_q  <= bus_wdata[CNT_W-1:0];
    end
  end

  assign push    = wr_samp && !fifo_full;
  assign fwe_evt = wr_samp && fifo_full;
  assign fe_evt  = pop && (occ == OCC_W'(1)) && !push;
  assign cmp_evt = tb_adv && !tb_roll && (CNT_W'(tb_cnt + 1'b1) == active);

  pwm_sample_fifo #(.DEPTH(FIFO_DEPTH), .W(CNT_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (swr_busy),
    .push  (push),
    .din   (bus_wdata[CNT_W-1:0]),
    .pop   (pop),
    .head  (fifo_head),
    .count (occ),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  pwm_timebase u_tb (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (swr_busy || !ctrl_q.en),
    .run     (loaded),
    .src     (ctrl_q.src),
    .hf_tick (hf_tick),
    .lf_tick (lf_tick),
    .presc   (ctrl_q.presc),
    .period  (per_q),
    .cnt     (tb_cnt),
    .adv     (tb_adv),
    .roll    (tb_roll)
  );

  pwm_duty_sel u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (swr_busy),
    .en         (ctrl_q.en),
    .roll       (tb_roll),
    .rep_code   (ctrl_q.rep),
    .fifo_empty (fifo_empty),
    .fifo_head  (fifo_head),
    .pop        (pop),
    .active     (active),
    .loaded     (loaded),
    .rep_cnt    (rep_cnt)
  );

  // sticky flags: a set in the same cycle wins over a write-1 clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fe_q  <= 1'b1;
      rov_q <= 1'b0;
      cmp_q <= 1'b0;
      fwe_q <= 1'b0;
    end else if (swr_busy) begin
      fe_q  <= 1'b1;
      rov_q <= 1'b0;
      cmp_q <= 1'b0;
      fwe_q <= 1'b0;
    end else begin
      fe_q  <= (fe_q  && !(wr_stat && bus_wdata[SB_FE]))  || fe_evt;
      rov_q <= (rov_q && !(wr_stat && bus_wdata[SB_ROV])) || tb_roll;
      cmp_q <= (cmp_q && !(wr_stat && bus_wdata[SB_CMP])) || cmp_evt;
      fwe_q <= (fwe_q && !(wr_stat && bus_wdata[SB_FWE])) || fwe_evt;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CTRL: bus_rdata = ctrl_pack(ctrl_q, swr_busy);
      OFS_STAT: begin
        bus_rdata[OCC_W-1:0] = occ;
        bus_rdata[SB_FE]     = fe_q;
        bus_rdata[SB_ROV]    = rov_q;
        bus_rdata[SB_CMP]    = cmp_q;
        bus_rdata[SB_FWE]    = fwe_q;
      end
      OFS_SAMP: if (ctrl_q.en && loaded) bus_rdata[CNT_W-1:0] = active;
      OFS_PER:  bus_rdata[CNT_W-1:0] = per_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign raw_wave = loaded && (tb_cnt < active);
  assign pwm_out  = shape_out(raw_wave, ctrl_q.outcfg);

endmodule

// File: rtl/pwm_fifo_gen_chk.sv
module pwm_fifo_gen_chk
  import pwm_fifo_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             bus_wr,
  input logic [ADDR_W-1:0]                bus_addr,
  input logic [DATA_W-1:0]                bus_wdata,
  input logic [$clog2(FIFO_DEPTH+1)-1:0]  occ,
  input logic                             swr_busy,
  input logic                             tb_roll,
  input logic [CNT_W-1:0]                 tb_cnt,
  input logic                             loaded,
  input logic [CNT_W-1:0]                 active,
  input logic                             ctrl_en,
  input logic [1:0]                       ctrl_out,
  input logic                             fwe_q,
  input logic                             pwm_out
);

  // R8
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= ($clog2(FIFO_DEPTH+1))'(FIFO_DEPTH));

  // R9
  full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !swr_busy && bus_addr == OFS_SAMP &&
     occ == ($clog2(FIFO_DEPTH+1))'(FIFO_DEPTH)) |=> fwe_q);

  // R11
  swr_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !swr_busy && bus_addr == OFS_CTRL && bus_wdata[CB_SWR])
      |=> (swr_busy && !ctrl_en));

  // R2
  roll_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tb_roll |=> (tb_cnt == '0));

  // R6
  zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && active == '0 && ctrl_out == 2'd0) |-> !pwm_out);

  // R13
  idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && !loaded) |-> (tb_cnt == '0));

  // R5
  forced_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_out[1] |-> !pwm_out);

endmodule

bind pwm_fifo_gen pwm_fifo_gen_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .occ       (occ),
  .swr_busy  (swr_busy),
  .tb_roll   (tb_roll),
  .tb_cnt    (tb_cnt),
  .loaded    (loaded),
  .active    (active),
  .ctrl_en   (ctrl_en),
  .ctrl_out  (ctrl_out),
  .fwe_q     (fwe_q),
  .pwm_out   (pwm_out)
);

// File: tb/sim_pwm_fifo_gen.sv
`timescale 1ns/1ps
module sim_pwm_fifo_gen;
  import pwm_fifo_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hf_tick = 1'b0;
  logic        lf_tick = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwm_out;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  localparam logic [31:0] RUN_BUS = 32'h0001_0001;

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    hf_tick = (cyc % 2) == 0;
    lf_tick = (cyc % 4) == 0;
  end

  pwm_fifo_gen u0 (
    .clk(clk), .rst_n(rst_n), .hf_tick(hf_tick), .lf_tick(lf_tick),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic soft_reset();
    logic [31:0] d;
    wr(OFS_CTRL, 32'h8);
    for (int i = 0; i < 20; i++) begin
      rd(OFS_CTRL, d);
      if (!d[3]) break;
    end
  endtask

  task automatic count_high(int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) h++;
    end
  endtask

  // lengths of the first five complete high runs
  task automatic get_runs(output int r[5]);
    int idx, len;
    logic prev;
    idx = 0; len = 0; prev = 1'b0;
    for (int i = 0; i < 5; i++) r[i] = -1;
    for (int i = 0; i < 400 && idx < 5; i++) begin
      @(negedge clk);
      if (pwm_out) len++;
      else begin
        if (prev) begin r[idx] = len; idx++; end
        len = 0;
      end
      prev = pwm_out;
    end
  endtask

  // high length and rise-to-rise length of one period
  task automatic get_edges(int skip, int maxc, output int hi, output int per);
    int rises;
    logic prev;
    rises = 0; prev = 1'b0; hi = 0; per = 0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (pwm_out && !prev) rises++;
      if (rises == skip + 2) break;
      if (rises == skip + 1) begin
        per++;
        if (pwm_out) hi++;
      end
      prev = pwm_out;
    end
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    rd(OFS_CTRL, d); check("R1 ctrl after reset", d, 32'h0);
    rd(OFS_PER, d);  check("R1 period after reset", d, 32'hFFFE);
    rd(OFS_STAT, d); check("R10 status after reset", d, 32'h8);
    rd(OFS_SAMP, d); check("R12 sample while disabled", d, 32'h0);
    check("R13 output idle", {31'b0, pwm_out}, 32'h0);
  endtask

  task automatic t_ctrl_readback();
    logic [31:0] d;
    wr(OFS_CTRL, 32'hFFF6_A5A6);
    rd(OFS_CTRL, d); check("R1 ctrl field readback", d, 32'h03C6_A5A6);
    wr(OFS_CTRL, 32'h0);
    wr(OFS_PER, 32'h0000_1234);
    rd(OFS_PER, d); check("R1 period readback", d, 32'h1234);
  endtask

  task automatic t_swr();
    logic [31:0] d;
    wr(OFS_PER, 5); wr(OFS_SAMP, 7); wr(OFS_CTRL, RUN_BUS);
    repeat (5) @(negedge clk);
    wr(OFS_CTRL, 32'h8);
    rd(OFS_CTRL, d); check("R11 busy bit set", {31'b0, d[3]}, 32'h1);
    wr(OFS_PER, 3);
    repeat (6) @(negedge clk);
    rd(OFS_CTRL, d); check("R11 ctrl cleared", d, 32'h0);
    rd(OFS_STAT, d); check("R11 status cleared", d, 32'h8);
    rd(OFS_PER, d);  check("R11 period restored, busy write ignored", d, 32'hFFFE);
    check("R11 output low", {31'b0, pwm_out}, 32'h0);
  endtask

  task automatic t_duty_basic();
    logic [31:0] d;
    int h;
    soft_reset();
    wr(OFS_PER, 6); wr(OFS_SAMP, 3); wr(OFS_CTRL, RUN_BUS);
    repeat (10) @(negedge clk);
    count_high(32, h); check("R6 R2 high cycles in 4 periods", h, 12);
    rd(OFS_SAMP, d); check("R12 active sample read", d, 3);
    rd(OFS_STAT, d); check("R10 flags set while running", d & 32'h7F, 32'h38);
    wr(OFS_CTRL, 32'h0);
    repeat (3) @(negedge clk);
    check("R13 output low when disabled", {31'b0, pwm_out}, 32'h0);
    wr(OFS_STAT, 32'h78);
    rd(OFS_STAT, d); check("R10 write-1 clear", d, 32'h0);
    rd(OFS_SAMP, d); check("R12 sample read disabled", d, 32'h0);
  endtask

  task automatic t_polarity();
    int h;
    soft_reset();
    wr(OFS_PER, 6); wr(OFS_SAMP, 3);
    wr(OFS_CTRL, RUN_BUS | (32'd1 << 18));
    repeat (10) @(negedge clk);
    count_high(32, h); check("R5 inverted high cycles", h, 20);
    wr(OFS_CTRL, RUN_BUS | (32'd2 << 18));
    count_high(32, h); check("R5 forced low", h, 0);
  endtask

  task automatic t_edges();
    int h;
    soft_reset();
    wr(OFS_PER, 4); wr(OFS_SAMP, 0); wr(OFS_CTRL, RUN_BUS);
    repeat (3) @(negedge clk);
    count_high(30, h); check("R6 zero sample low", h, 0);
    soft_reset();
    wr(OFS_PER, 4); wr(OFS_SAMP, 9); wr(OFS_CTRL, RUN_BUS);
    repeat (3) @(negedge clk);
    count_high(30, h); check("R6 oversized sample high", h, 30);
  endtask

  task automatic t_repeat(logic [1:0] code, int s0, int s1);
    logic [31:0] d;
    int r[5];
    int n;
    soft_reset();
    n = 1 << code;
    wr(OFS_PER, 6); wr(OFS_SAMP, s0); wr(OFS_SAMP, s1);
    rd(OFS_STAT, d); check("R8 occupancy two", d & 32'h7, 2);
    wr(OFS_CTRL, RUN_BUS | (32'(code) << 1));
    get_runs(r);
    for (int i = 0; i < 5; i++)
      check($sformatf("R7 R8 run %0d code %0d", i, code), r[i], (i < n) ? s0 : s1);
  endtask

  task automatic t_prescale();
    int hi, per;
    soft_reset();
    wr(OFS_PER, 2); wr(OFS_SAMP, 1);
    wr(OFS_CTRL, RUN_BUS | (32'd2 << 4));
    get_edges(1, 200, hi, per);
    check("R3 prescaled high", hi, 3);
    check("R3 prescaled period", per, 12);
  endtask

  task automatic t_sources();
    logic [31:0] d;
    int hi, per, h;
    soft_reset();
    wr(OFS_PER, 2); wr(OFS_SAMP, 1); wr(OFS_CTRL, 32'h0002_0001);
    get_edges(1, 200, hi, per);
    check("R4 hf source high", hi, 2);
    check("R4 hf source period", per, 8);
    soft_reset();
    wr(OFS_PER, 2); wr(OFS_SAMP, 1); wr(OFS_CTRL, 32'h0003_0001);
    get_edges(1, 200, hi, per);
    check("R4 lf source high", hi, 4);
    check("R4 lf source period", per, 16);
    soft_reset();
    wr(OFS_PER, 2); wr(OFS_SAMP, 1); wr(OFS_SAMP, 3); wr(OFS_CTRL, 32'h0000_0001);
    repeat (3) @(negedge clk);
    count_high(40, h); check("R4 source off frozen", h, 40);
    rd(OFS_STAT, d); check("R4 R8 no pop while frozen", d & 32'h17, 32'h1);
  endtask

  task automatic t_fifo_full();
    logic [31:0] d;
    int r[5];
    soft_reset();
    wr(OFS_PER, 20);
    for (int i = 1; i <= 4; i++) wr(OFS_SAMP, i);
    rd(OFS_STAT, d); check("R8 occupancy full", d, 32'hC);
    wr(OFS_SAMP, 9);
    rd(OFS_STAT, d); check("R9 write error flag", d, 32'h4C);
    wr(OFS_CTRL, RUN_BUS);
    get_runs(r);
    for (int i = 0; i < 5; i++)
      check($sformatf("R9 R8 run %0d", i), r[i], (i < 4) ? i + 1 : 4);
  endtask

  task automatic t_clamp();
    logic [31:0] d;
    int hi, per;
    soft_reset();
    wr(OFS_PER, 32'hFFFF);
    rd(OFS_PER, d); check("R1 period readback max", d, 32'hFFFF);
    wr(OFS_SAMP, 1); wr(OFS_CTRL, RUN_BUS);
    get_edges(0, 70000, hi, per);
    check("R2 clamped high", hi, 1);
    check("R2 clamped period", per, 65536);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_ctrl_readback();
    t_swr();
    t_duty_basic();
    t_polarity();
    t_edges();
    t_repeat(2'd1, 2, 5);
    t_repeat(2'd2, 1, 4);
    t_prescale();
    t_sources();
    t_fifo_full();
    t_clamp();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule